// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block turns a wide bundle of already synchronized GPIO lines into a fixed set of interrupt channels. Each channel uses a programmable index to choose one GPIO line and applies one of four sense modes to it: rising edge, falling edge, high level or low level. A detected event sets that channel's status bit. The status bit drives an active-high interrupt line to the parent controller and holds until software clears it.

Software reaches the block through a simple 32-bit register port: a write strobe with address and data, and a combinational read-data return. Each channel's configuration is packed into a byte of a shared select register, together with its enable flag. The two-bit sense fields for the channels are spread over two registers. Reconfiguring a channel re-arms its edge detector, so changing the source or the enable never produces a false edge.

Top module: `gpio_int_selector`

## Requirements
- R1: After reset every register reads 0 and every `irq_out` bit is 0.
- R2: Channel c is configured in byte lane c%4 of the select register at address 0x30 + 4*(c/4). Bit 7 of the lane is the enable and bits 6:0 are the source index. All bits read back as written.
- R3: Channels 0 to 15 have sense fields at address 0x24 and channels 16 to 31 at address 0x28. Each field is two bits at position 2*(c%16) and reads back as written.
- R4: Sense code 0 (rising): a 0-to-1 change of the selected input on an enabled channel sets its status bit at the next clock edge. A 1-to-0 change does not.
- R5: Sense code 1 (falling): a 1-to-0 change sets the status bit. A 0-to-1 change does not.
- R6: Sense code 2 (high level) and sense code 3 (low level) set the status bit in every cycle in which the selected input holds that level. Clearing the bit while the level persists therefore has no lasting effect.
- R7: The status register is at address 0x20, one bit per channel. Writing 0 to a bit clears it. Writing 1 leaves it unchanged. Only a write to this address can clear a bit.
- R8: `irq_out[c]` equals status bit c at all times.
- R9: A source index at or above `N_SRC` selects a constant 0 input.
- R10: In the cycle after a write that changes a channel's select byte, that channel's edge detection is suppressed, so switching source or enable never creates an edge.
- R11: A disabled channel sets no status bit, but it keeps a status bit that is already set.
- R12: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on `bus_addr`) |
| gpio_in | input | N_SRC | Synchronized GPIO lines |
| irq_out | output | N_CH | Per-channel active-high interrupt level |

## Verification
The assertions assume that `gpio_in` is already synchronous to `clk` and that reset is held for several cycles, so that the sampled history after reset is defined. They also assume that `bus_we` is only asserted for one address per cycle. The bench changes GPIO lines and issues writes only on falling clock edges. It never drives a line that an unintended channel is watching, so every status change it sees has a single known cause. It keeps all `N_SRC` lines at known values from time zero.

// File: rtl/gis_pkg.sv
package gis_pkg;

  typedef enum logic [1:0] {
    SNS_RISE = 2'd0,
    SNS_FALL = 2'd1,
    SNS_HIGH = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;

  localparam logic [7:0] ADR_STATUS = 8'h20;
  localparam logic [7:0] ADR_SENSE0 = 8'h24;
  localparam logic [7:0] ADR_SEL0   = 8'h30;
  localparam int         SRC_W      = 7;
  localparam int         LANES_SEL  = 4;
  localparam int         LANES_SNS  = 16;

  function automatic logic [7:0] sel_reg_addr(input int ch);
    return ADR_SEL0 + 8'(4 * (ch / LANES_SEL));
  endfunction

  function automatic logic [7:0] sns_reg_addr(input int ch);
    return ADR_SENSE0 + 8'(4 * (ch / LANES_SNS));
  endfunction

  function automatic int sel_lane(input int ch);
    return 8 * (ch % LANES_SEL);
  endfunction

  function automatic int sns_lane(input int ch);
    return 2 * (ch % LANES_SNS);
  endfunction

  // armed = 0 masks the edge modes for one cycle after reconfiguration
  function automatic logic detect(input sense_e s, input logic cur,
                                  input logic prev, input logic armed);
    case (s)
      SNS_RISE: return armed & cur & ~prev;
      SNS_FALL: return armed & ~cur & prev;
      SNS_HIGH: return cur;
      default:  return ~cur;
    endcase
  endfunction

endpackage

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
#(
  parameter int N_CH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [7:0]           addr,
  input  logic [31:0]          wdata,
  input  logic [N_CH-1:0]      status,
  output logic [31:0]          rdata,
  output logic [SRC_W-1:0]     src_idx [N_CH],
  output logic [N_CH-1:0]      en,
  output sense_e               sense   [N_CH],
  output logic [N_CH-1:0]      reload
);

  logic [7:0] sel_q [N_CH];
  logic [1:0] sns_q [N_CH];

  always_ff @(posedge clk) begin
    for (int ch = 0; ch < N_CH; ch++) begin
      if (!rst_n) begin
        sel_q[ch]  <= '0;
        sns_q[ch]  <= '0;
        reload[ch] <= 1'b0;
      end else begin
        if (we && addr == sel_reg_addr(ch)) begin
          sel_q[ch]  <= wdata[sel_lane(ch) +: 8];
          reload[ch] <= (wdata[sel_lane(ch) +: 8] != sel_q[ch]);
        end else begin
          reload[ch] <= 1'b0;
        end
        if (we && addr == sns_reg_addr(ch))
          sns_q[ch] <= wdata[sns_lane(ch) +: 2];
      end
    end
  end

  always_comb begin
    for (int ch = 0; ch < N_CH; ch++) begin
      src_idx[ch] = sel_q[ch][SRC_W-1:0];
      en[ch]      = sel_q[ch][7];
      sense[ch]   = sense_e'(sns_q[ch]);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_STATUS) rdata[N_CH-1:0] = status;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (addr == sel_reg_addr(ch)) rdata[sel_lane(ch) +: 8] = sel_q[ch];
      if (addr == sns_reg_addr(ch)) rdata[sns_lane(ch) +: 2] = sns_q[ch];
    end
  end

endmodule

// File: rtl/gis_channel.sv
module gis_channel
  import gis_pkg::*;
#(
  parameter int N_SRC = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  gpio,
  input  logic [SRC_W-1:0]  src_idx,
  input  logic              en,
  input  sense_e            sense,
  input  logic              reload,
  input  logic              clr_we,
  input  logic              clr_keep,
  output logic              status,
  output logic              event_o
);

  localparam int SPAN = 2 ** SRC_W;

  logic [SPAN-1:0] padded;
  logic            cur;
  logic            prev_q;

  generate
    if (N_SRC < SPAN) begin : g_pad
      assign padded = {{(SPAN - N_SRC){1'b0}}, gpio};
    end else begin : g_full
      assign padded = gpio[SPAN-1:0];
    end
  endgenerate

  assign cur     = padded[src_idx];
  assign event_o = en & detect(sense, cur, prev_q, ~reload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      status <= 1'b0;
    end else begin
      prev_q <= cur;
      if (event_o)
        status <= 1'b1;
      else if (clr_we && !clr_keep)
        status <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_int_selector.sv
module gpio_int_selector
  import gis_pkg::*;
#(
  parameter int N_CH  = 32,
  parameter int N_SRC = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  gpio_in,
  output logic [N_CH-1:0]   irq_out
);

  logic [SRC_W-1:0] src_idx [N_CH];
  sense_e           sense   [N_CH];
  logic [N_CH-1:0]  ch_en;
  logic [N_CH-1:0]  ch_reload;
  logic [N_CH-1:0]  ch_event;
  logic [N_CH-1:0]  ch_edge;
  logic [N_CH-1:0]  status;
  logic             clr_we;

  assign clr_we  = bus_we && (bus_addr == ADR_STATUS);
  assign irq_out = status;

  gis_regs #(.N_CH(N_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .status  (status),
    .rdata   (bus_rdata),
    .src_idx (src_idx),
    .en      (ch_en),
    .sense   (sense),
    .reload  (ch_reload)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign ch_edge[c] = (sense[c] == SNS_RISE) || (sense[c] == SNS_FALL);
      gis_channel #(.N_SRC(N_SRC)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpio     (gpio_in),
        .src_idx  (src_idx[c]),
        .en       (ch_en[c]),
        .sense    (sense[c]),
        .reload   (ch_reload[c]),
        .clr_we   (clr_we),
        .clr_keep (bus_wdata[c]),
        .status   (status[c]),
        .event_o  (ch_event[c])
      );
    end
  endgenerate

endmodule

// File: rtl/gis_checker.sv
module gis_checker
  import gis_pkg::*;
#(
  parameter int N_CH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [N_CH-1:0]  irq_out,
  input logic [N_CH-1:0]  ch_event,
  input logic [N_CH-1:0]  ch_reload,
  input logic [N_CH-1:0]  ch_en,
  input logic [N_CH-1:0]  ch_edge
);

  AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_event) |=> ((irq_out & $past(ch_event)) == $past(ch_event))); // R12

  AST_NO_SET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & ~$past(irq_out) & ~$past(ch_event)) == '0)); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_event & ~ch_en) == '0)); // R11

  AST_RELOAD_MUTES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_event & ch_reload & ch_edge) == '0)); // R10

  AST_STATUS_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_STATUS) |-> (bus_rdata == 32'(irq_out))); // R8

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == ADR_STATUS) |=> ((~irq_out & $past(irq_out)) == '0)); // R7

endmodule

bind gpio_int_selector gis_checker #(.N_CH(N_CH)) u_gis_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .ch_event  (ch_event),
  .ch_reload (ch_reload),
  .ch_en     (ch_en),
  .ch_edge   (ch_edge)
);

// File: tb/test_gpio_int_selector.sv
module test_gpio_int_selector;

  localparam int N_CH  = 32;
  localparam int N_SRC = 96;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_we = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [N_SRC-1:0] gpio_in = '0;
  logic [N_CH-1:0]  irq_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  int  sh_src [N_CH];
  bit  sh_en  [N_CH];

  always #2.5 clk = ~clk;

  gpio_int_selector #(.N_CH(N_CH), .N_SRC(N_SRC)) i_gpio_int_selector (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] sel_word(input int k);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++)
      w[8*l +: 8] = {sh_en[4*k+l] ? 1'b1 : 1'b0, 7'(sh_src[4*k+l])};
    return w;
  endfunction

  task automatic put_sel(input int k);
    wr(8'h30 + 8'(4*k), sel_word(k));
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", 32'(irq_out), 32'h0);
    for (int a = 8'h20; a <= 8'h3C; a += 4) begin
      rd(8'(a), d);
      chk("R1 reg", d, 32'h0);
    end

    // R2 select layout sweep, channels kept disabled
    for (int c = 0; c < N_CH; c++) begin sh_src[c] = (c*5 + 3) % 128; sh_en[c] = 0; end
    for (int k = 0; k < 8; k++) put_sel(k);
    for (int k = 0; k < 8; k++) begin
      rd(8'h30 + 8'(4*k), d);
      chk("R2 readback", d, sel_word(k));
    end

    // R3 sense layout
    wr(8'h24, 32'hA5C3_1E96);
    wr(8'h28, 32'h3C69_F00D);
    rd(8'h24, d); chk("R3 sense0", d, 32'hA5C3_1E96);
    rd(8'h28, d); chk("R3 sense1", d, 32'h3C69_F00D);
    chk("R11 no irq while disabled", 32'(irq_out), 32'h0);

    // Working configuration: channel c watches line 3c, rising, enabled
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h0);
    for (int c = 0; c < N_CH; c++) begin sh_src[c] = 3*c; sh_en[c] = 1; end
    for (int k = 0; k < 8; k++) put_sel(k);
    wr(8'h20, 32'h0);
    chk("R1 quiet after config", 32'(irq_out), 32'h0);

    // R4 rising sweep
    for (int c = 0; c < N_CH; c++) begin
      gpio_in[3*c] = 1'b1; tick();
      chk("R4 rise sets", 32'(irq_out), 32'(1) << c);
      gpio_in[3*c] = 1'b0; tick();
      chk("R4 fall ignored", 32'(irq_out), 32'(1) << c);
      wr(8'h20, ~(32'(1) << c));
      chk("R7 clear by zero", 32'(irq_out), 32'h0);
    end

    // R5 falling sweep
    wr(8'h24, 32'h5555_5555);
    wr(8'h28, 32'h5555_5555);
    for (int c = 0; c < N_CH; c++) begin
      gpio_in[3*c] = 1'b1; tick();
      chk("R5 rise ignored", 32'(irq_out), 32'h0);
      gpio_in[3*c] = 1'b0; tick();
      chk("R5 fall sets", 32'(irq_out), 32'(1) << c);
      rd(8'h20, d);
      chk("R8 status reads irq", d, 32'(1) << c);
      wr(8'h20, 32'hFFFF_FFFF);
      chk("R7 ones keep", 32'(irq_out), 32'(1) << c);
      wr(8'h20, 32'h0);
      chk("R7 cleared", 32'(irq_out), 32'h0);
    end

    // R6 level high on channel 0 and R12 event over clear
    wr(8'h24, 32'h5555_5556);
    gpio_in[0] = 1'b1; tick();
    chk("R6 high sets", 32'(irq_out), 32'h1);
    wr(8'h20, 32'h0);
    chk("R12 event beats clear", 32'(irq_out), 32'h1);
    gpio_in[0] = 1'b0; tick(); tick();
    chk("R6 sticky after level ends", 32'(irq_out), 32'h1);
    wr(8'h20, 32'h0);
    chk("R6 clear after level", 32'(irq_out), 32'h0);

    // R6 level low on channel 1 (line 3 is low)
    wr(8'h24, 32'h5555_555D);
    tick();
    chk("R6 low sets", 32'(irq_out), 32'h2);
    gpio_in[3] = 1'b1;
    wr(8'h20, 32'h0);
    chk("R6 low clear", 32'(irq_out), 32'h0);

    // R9 out-of-range source on channel 2
    gpio_in[3] = 1'b0;
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h0);
    sh_src[2] = 100; put_sel(0);
    wr(8'h24, 32'h0000_0030);
    tick();
    chk("R9 index 100 reads low", 32'(irq_out), 32'h4);
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h0);
    gpio_in = '1; tick(); tick();
    chk("R9 no edge from absent line", 32'(irq_out[2]), 32'h0);
    gpio_in = '0; tick();
    wr(8'h20, 32'h0);
    sh_src[2] = 6; put_sel(0);

    // R10 source switch onto a high line does not fire
    gpio_in[50] = 1'b1; tick();
    sh_src[4] = 50; put_sel(1);
    tick(); tick();
    chk("R10 source switch quiet", 32'(irq_out), 32'h0);
    gpio_in[50] = 1'b0; tick();
    gpio_in[50] = 1'b1; tick();
    chk("R10 detector live after switch", 32'(irq_out), 32'h10);
    gpio_in[50] = 1'b0;
    wr(8'h20, 32'h0);
    sh_src[4] = 12; put_sel(1);

    // R11 disabled channel ignores edge; R10 enable onto high line quiet
    sh_en[4] = 0; put_sel(1);
    gpio_in[12] = 1'b1; tick(); tick();
    chk("R11 disabled ignores edge", 32'(irq_out), 32'h0);
    sh_en[4] = 1; put_sel(1);
    tick(); tick();
    chk("R10 enable quiet", 32'(irq_out), 32'h0);
    gpio_in[12] = 1'b0; tick();
    gpio_in[12] = 1'b1; tick();
    chk("R4 enabled again", 32'(irq_out), 32'h10);
    sh_en[4] = 0; put_sel(1);
    tick(); tick();
    chk("R11 keeps status", 32'(irq_out), 32'h10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule